// File: doc/BRIEF.md
# Multi-Mode 8-Bit Waveform Timer

The block is an 8-bit counter with one compare register, one waveform output and two event flags (overflow and compare). A two-bit mode, taken from two separate bits of the control byte, selects one of four counting schemes: free-running normal, clear-on-compare (CTC), fast PWM and phase-correct PWM. The mode sets the counting sequence, the TOP value, when a freshly written compare value takes effect, and the count at which the overflow flag rises.

Software reaches the block through a small register port: a write strobe, a two-bit address, write data and combinational read data. The counter advances by one on each clock where the clock-select field is nonzero and the external `tick` input is high. A direction state machine with two states, DIR_UP and DIR_DOWN, drives the phase-correct sequence. DIR_UP goes to DIR_DOWN on the step taken at 0xFF. DIR_DOWN goes to DIR_UP on the step taken at 0x00. In every other mode the machine is held in DIR_UP.

Top module: `wavetimer8`

## Requirements
- R1: After reset all four registers read 0x00, and `wave_out`, `irq_ovf` and `irq_cmp` are 0.
- R2: The control register sits at address 0. Bit 6 is mode bit 0, bit 3 is mode bit 1, bits 5:4 are the output action and bits 2:0 are clock select. Bit 7 is a write-only force strobe and always reads 0. The mode codes are 0 normal, 1 phase-correct, 2 CTC and 3 fast.
- R3: In normal mode the counter at address 1 counts up and wraps from 0xFF to 0x00. The step taken at 0xFF sets the overflow flag, which is bit 0 of the status register at address 3.
- R4: In normal mode and CTC, a compare value written to address 2 takes effect at once. A step taken where the counter equals the compare value sets the compare flag (status bit 1) and applies the action. The actions are 01 toggle, 10 clear and 11 set. Action 00 holds `wave_out` low.
- R5: In CTC, a step taken at the compare value loads 0x00 into the counter.
- R6: Writing the control register with bit 7 set, in normal mode or CTC, applies the written action to the output at once. It sets no flag and does not change the counter.
- R7: The force strobe has no effect on the output in either PWM mode.
- R8: In fast PWM, compare writes go to a buffer that reads back at address 2. The buffer is copied to the active compare on the step taken at 0xFF. Action 10 clears the output on a match and sets it on the step at 0xFF. Action 11 does the opposite. Action 01 holds `wave_out` low.
- R9: In phase-correct PWM, the counter runs up to 0xFF and then down to 0x00. The buffer is loaded on the step at 0xFF, and the step taken at 0x00 while counting down sets the overflow flag. Action 10 clears the output on an up-count match and sets it on a down-count match.
- R10: Writing 1 to a status flag bit clears that flag. Status bit 4 enables overflow interrupts and bit 5 enables compare interrupts. Each interrupt output is high while its flag and its enable are both set.
- R11: When clock select is 000 the counter does not change, whatever `tick` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable, sampled each clock |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 control, 1 counter, 2 compare, 3 status |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| wave_out | output | 1 | Waveform output |
| irq_ovf | output | 1 | Overflow interrupt |
| irq_cmp | output | 1 | Compare interrupt |

## Verification
The assertions assume that `addr`, `wdata`, `wr_en` and `tick` are settled levels at each rising edge. They also assume that a counter write and a counting step in the same cycle resolve in favour of the write, which the properties exclude through their antecedents. The stimulus keeps `tick` low during every register write, so each counting step comes from a separate, exactly counted burst of `tick`. It changes the mode only between bursts, so no property sees a mode change in the middle of a step.

// File: rtl/wavetimer_pkg.sv
package wavetimer_pkg;
    typedef enum logic [1:0] {
        WG_NORMAL = 2'd0,
        WG_PHASE  = 2'd1,
        WG_CTC    = 2'd2,
        WG_FAST   = 2'd3
    } wg_mode_e;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    typedef enum logic [1:0] {
        ACT_OFF    = 2'd0,
        ACT_TOGGLE = 2'd1,
        ACT_CLEAR  = 2'd2,
        ACT_SET    = 2'd3
    } act_e;
endpackage

// File: rtl/wt_counter.sv
module wt_counter
    import wavetimer_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_i,
    input  logic         ld_i,
    input  logic [W-1:0] ld_val_i,
    input  wg_mode_e     mode_i,
    input  logic [W-1:0] cmp_i,
    output logic [W-1:0] cnt_o,
    output dir_e         dir_o,
    output logic         match_o,
    output logic         ovf_o,
    output logic         top_o
);
    localparam logic [W-1:0] MAXV = '1;
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] cnt_q, cnt_d;
    dir_e         st_q, st_d;
    logic         adv, at_max, at_zero;

    assign adv     = step_i & ~ld_i;
    assign at_max  = (cnt_q == MAXV);
    assign at_zero = (cnt_q == '0);

    assign match_o = adv && (cnt_q == cmp_i);
    assign ovf_o   = adv && ((mode_i == WG_PHASE) ? (st_q == DIR_DOWN && at_zero) : at_max);
    assign top_o   = adv && at_max;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (ld_i) begin
            cnt_d = ld_val_i;
        end else if (step_i) begin
            unique case (mode_i)
                WG_NORMAL, WG_FAST: cnt_d = cnt_q + ONE;
                WG_CTC:             cnt_d = match_o ? '0 : cnt_q + ONE;
                WG_PHASE: begin
                    unique case (st_q)
                        DIR_UP: begin
                            if (at_max) begin
                                cnt_d = MAXV - ONE;
                                st_d  = DIR_DOWN;
                            end else begin
                                cnt_d = cnt_q + ONE;
                            end
                        end
                        DIR_DOWN: begin
                            if (at_zero) begin
                                cnt_d = ONE;
                                st_d  = DIR_UP;
                            end else begin
                                cnt_d = cnt_q - ONE;
                            end
                        end
                    endcase
                end
            endcase
        end
        if (mode_i != WG_PHASE) st_d = DIR_UP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            st_q  <= DIR_UP;
        end else begin
            cnt_q <= cnt_d;
            st_q  <= st_d;
        end
    end

    assign cnt_o = cnt_q;
    assign dir_o = st_q;

    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !ld_i) |=> $stable(cnt_q));
    a_r5_ctc_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == WG_CTC && step_i && !ld_i && cnt_q == cmp_i) |=> (cnt_q == '0));
    a_r9_down_count: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == WG_PHASE && st_q == DIR_DOWN && step_i && !ld_i && !at_zero)
        |=> (cnt_q == $past(cnt_q) - ONE));
endmodule

// File: rtl/wt_cmpbuf.sv
module wt_cmpbuf #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic         pwm_i,
    input  logic         reload_i,
    output logic [W-1:0] buf_o,
    output logic [W-1:0] act_o
);
    logic [W-1:0] buf_q, act_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q <= '0;
            act_q <= '0;
        end else begin
            if (wr_i) buf_q <= wdata_i;
            if (wr_i && !pwm_i)          act_q <= wdata_i;
            else if (reload_i && pwm_i)  act_q <= buf_q;
        end
    end

    assign buf_o = buf_q;
    assign act_o = act_q;

    a_r8_buffered: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_i && !reload_i) |=> $stable(act_q));
endmodule

// File: rtl/wt_wave.sv
module wt_wave
    import wavetimer_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  wg_mode_e mode_i,
    input  act_e     act_i,
    input  logic     match_i,
    input  logic     top_i,
    input  dir_e     dir_i,
    input  logic     force_i,
    input  act_e     force_act_i,
    output logic     wave_o
);
    logic wave_q, wave_d, pwm, visible;

    function automatic logic apply_act(input act_e a, input logic cur);
        unique case (a)
            ACT_OFF:    apply_act = cur;
            ACT_TOGGLE: apply_act = ~cur;
            ACT_CLEAR:  apply_act = 1'b0;
            ACT_SET:    apply_act = 1'b1;
        endcase
    endfunction

    assign pwm = (mode_i == WG_FAST) || (mode_i == WG_PHASE);

    always_comb begin
        wave_d = wave_q;
        if (force_i) begin
            wave_d = apply_act(force_act_i, wave_q);
        end else begin
            unique case (mode_i)
                WG_NORMAL, WG_CTC: begin
                    if (match_i) wave_d = apply_act(act_i, wave_q);
                end
                WG_FAST: begin
                    if (match_i && act_i == ACT_CLEAR) wave_d = 1'b0;
                    if (match_i && act_i == ACT_SET)   wave_d = 1'b1;
                    if (top_i && act_i == ACT_CLEAR)   wave_d = 1'b1;
                    if (top_i && act_i == ACT_SET)     wave_d = 1'b0;
                end
                WG_PHASE: begin
                    if (match_i && act_i == ACT_CLEAR) wave_d = (dir_i == DIR_DOWN);
                    if (match_i && act_i == ACT_SET)   wave_d = (dir_i == DIR_UP);
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wave_q <= 1'b0;
        else        wave_q <= wave_d;
    end

    assign visible = (act_i != ACT_OFF) && !(pwm && act_i == ACT_TOGGLE);
    assign wave_o  = wave_q & visible;

    a_r4_set_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        (!force_i && match_i && (mode_i == WG_NORMAL || mode_i == WG_CTC) && act_i == ACT_SET)
        |=> wave_q);
endmodule

// File: rtl/wavetimer8.sv
module wavetimer8
    import wavetimer_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         wr_en,
    input  logic [1:0]   addr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    output logic         wave_out,
    output logic         irq_ovf,
    output logic         irq_cmp
);
    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_CNT  = 2'd1;
    localparam logic [1:0] A_CMP  = 2'd2;
    localparam logic [1:0] A_STAT = 2'd3;

    logic [6:0]   ctrl_q;
    logic         ovf_f, cmp_f, en_ovf, en_cmp;
    wg_mode_e     mode, mode_w;
    logic         pwm, pwm_w, step, force_cmp;
    logic         wr_ctrl, wr_cnt, wr_cmp, wr_stat;
    logic [W-1:0] cnt, cmp_buf, cmp_act;
    dir_e         dir;
    logic         ev_match, ev_ovf, ev_top;

    assign wr_ctrl = wr_en && addr == A_CTRL;
    assign wr_cnt  = wr_en && addr == A_CNT;
    assign wr_cmp  = wr_en && addr == A_CMP;
    assign wr_stat = wr_en && addr == A_STAT;

    assign mode   = wg_mode_e'({ctrl_q[3], ctrl_q[6]});
    assign mode_w = wg_mode_e'({wdata[3], wdata[6]});
    assign pwm    = (mode == WG_FAST) || (mode == WG_PHASE);
    assign pwm_w  = (mode_w == WG_FAST) || (mode_w == WG_PHASE);
    assign step   = (ctrl_q[2:0] != 3'b000) && tick;
    assign force_cmp = wr_ctrl && wdata[7] && !pwm_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            ovf_f  <= 1'b0;
            cmp_f  <= 1'b0;
            en_ovf <= 1'b0;
            en_cmp <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl_q <= wdata[6:0];
            if (wr_stat) begin
                en_ovf <= wdata[4];
                en_cmp <= wdata[5];
                if (wdata[0]) ovf_f <= 1'b0;
                if (wdata[1]) cmp_f <= 1'b0;
            end
            if (ev_ovf)   ovf_f <= 1'b1;
            if (ev_match) cmp_f <= 1'b1;
        end
    end

    wt_counter #(.W(W)) u_counter (
        .clk(clk), .rst_n(rst_n), .step_i(step), .ld_i(wr_cnt), .ld_val_i(wdata),
        .mode_i(mode), .cmp_i(cmp_act), .cnt_o(cnt), .dir_o(dir),
        .match_o(ev_match), .ovf_o(ev_ovf), .top_o(ev_top)
    );

    wt_cmpbuf #(.W(W)) u_cmpbuf (
        .clk(clk), .rst_n(rst_n), .wr_i(wr_cmp), .wdata_i(wdata), .pwm_i(pwm),
        .reload_i(ev_top), .buf_o(cmp_buf), .act_o(cmp_act)
    );

    wt_wave u_wave (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .act_i(act_e'(ctrl_q[5:4])),
        .match_i(ev_match), .top_i(ev_top), .dir_i(dir), .force_i(force_cmp),
        .force_act_i(act_e'(wdata[5:4])), .wave_o(wave_out)
    );

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_CTRL: rdata[6:0] = ctrl_q;
            A_CNT:  rdata = cnt;
            A_CMP:  rdata = cmp_buf;
            A_STAT: begin
                rdata[0] = ovf_f;
                rdata[1] = cmp_f;
                rdata[4] = en_ovf;
                rdata[5] = en_cmp;
            end
        endcase
    end

    assign irq_ovf = ovf_f & en_ovf;
    assign irq_cmp = cmp_f & en_cmp;

    a_r3_ovf_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ovf |=> ovf_f);
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && wdata[0] && !ev_ovf) |=> !ovf_f);
endmodule

// File: tb/wavetimer8_bench.sv
module wavetimer8_bench;
    localparam time CLK_P = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       wave_out, irq_ovf, irq_cmp;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        int         sel;
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sb_q[$];

    always #(CLK_P/2) clk = ~clk;

    wavetimer8 u_wavetimer8 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .wave_out(wave_out),
        .irq_ovf(irq_ovf), .irq_cmp(irq_cmp)
    );

    // monitor: pops expected items and compares against the ports
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it = sb_q.pop_front();
            case (it.sel)
                0:       act = rdata;
                1:       act = {7'd0, wave_out};
                2:       act = {7'd0, irq_ovf};
                default: act = {7'd0, irq_cmp};
            endcase
            n_cmp++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s: actual 0x%02h expected 0x%02h", it.tag, act, it.exp);
            end
        end
    end

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic run_ticks(input int n);
        @(posedge clk); #1;
        tick = 1'b1;
        repeat (n) @(posedge clk);
        #1;
        tick = 1'b0;
    endtask

    // sel: 0 register at a, 1 wave_out, 2 irq_ovf, 3 irq_cmp
    task automatic expect_item(input int sel, input logic [1:0] a, input logic [7:0] e, input string tag);
        item_t it;
        @(posedge clk); #1;
        addr = a;
        it.sel = sel; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk); #1;
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        expect_item(0, 2'd0, 8'h00, "R1 ctrl");
        expect_item(0, 2'd1, 8'h00, "R1 count");
        expect_item(0, 2'd2, 8'h00, "R1 compare");
        expect_item(0, 2'd3, 8'h00, "R1 status");
        expect_item(1, 2'd0, 8'h00, "R1 wave");
        expect_item(2, 2'd0, 8'h00, "R1 irq_ovf");

        // R3 normal wrap and overflow
        bus_write(2'd0, 8'h01);
        bus_write(2'd1, 8'hFD);
        run_ticks(3);
        expect_item(0, 2'd1, 8'h00, "R3 wrap");
        expect_item(0, 2'd3, 8'h01, "R3 ovf flag");
        bus_write(2'd3, 8'h01);
        expect_item(0, 2'd3, 8'h00, "R10 flag clear");

        // R4 immediate compare, toggle
        bus_write(2'd0, 8'h11);
        bus_write(2'd2, 8'h05);
        bus_write(2'd1, 8'h03);
        run_ticks(3);
        expect_item(1, 2'd0, 8'h01, "R4 toggle");
        expect_item(0, 2'd3, 8'h02, "R4 cmp flag");
        expect_item(0, 2'd1, 8'h06, "R4 count");

        // R6 force in normal mode, R2 strobe reads 0
        bus_write(2'd3, 8'h02);
        bus_write(2'd0, 8'h91);
        expect_item(1, 2'd0, 8'h00, "R6 force toggle");
        expect_item(0, 2'd3, 8'h00, "R6 no flag");
        expect_item(0, 2'd0, 8'h11, "R2 strobe reads 0");
        expect_item(0, 2'd1, 8'h06, "R6 count kept");

        // R5 CTC with set action
        bus_write(2'd0, 8'h39);
        bus_write(2'd2, 8'h04);
        bus_write(2'd1, 8'h02);
        run_ticks(3);
        expect_item(0, 2'd1, 8'h00, "R5 clear at compare");
        expect_item(1, 2'd0, 8'h01, "R4 set on match");
        expect_item(0, 2'd3, 8'h02, "R5 cmp only");

        // R6 force in CTC does not clear the counter
        bus_write(2'd3, 8'h02);
        bus_write(2'd1, 8'h04);
        bus_write(2'd0, 8'hA9);
        expect_item(1, 2'd0, 8'h00, "R6 force clear");
        expect_item(0, 2'd1, 8'h04, "R6 ctc count kept");
        expect_item(0, 2'd3, 8'h00, "R6 ctc no flag");

        // R8 fast PWM buffering
        bus_write(2'd0, 8'h69);
        bus_write(2'd2, 8'h02);
        expect_item(0, 2'd2, 8'h02, "R8 buffer readback");
        bus_write(2'd1, 8'h01);
        run_ticks(2);
        expect_item(0, 2'd3, 8'h00, "R8 old compare still active");
        bus_write(2'd1, 8'hFF);
        run_ticks(1);
        expect_item(1, 2'd0, 8'h01, "R8 set at wrap");
        expect_item(0, 2'd1, 8'h00, "R8 wrap count");
        expect_item(0, 2'd3, 8'h01, "R8 ovf at max");
        bus_write(2'd0, 8'hE9);
        expect_item(1, 2'd0, 8'h01, "R7 force ignored");
        expect_item(0, 2'd0, 8'h69, "R2 ctrl readback");
        bus_write(2'd0, 8'h59);
        expect_item(1, 2'd0, 8'h00, "R8 action 01 low");
        bus_write(2'd0, 8'h69);
        expect_item(1, 2'd0, 8'h01, "R8 restored");
        run_ticks(3);
        expect_item(1, 2'd0, 8'h00, "R8 clear on match");
        expect_item(0, 2'd3, 8'h03, "R8 flags");

        // R9 phase-correct
        bus_write(2'd0, 8'h61);
        bus_write(2'd3, 8'h03);
        bus_write(2'd2, 8'h80);
        bus_write(2'd1, 8'hFE);
        run_ticks(2);
        expect_item(0, 2'd1, 8'hFE, "R9 turn at top");
        expect_item(0, 2'd3, 8'h00, "R9 no ovf at top");
        bus_write(2'd1, 8'h81);
        run_ticks(2);
        expect_item(1, 2'd0, 8'h01, "R9 set on down match");
        expect_item(0, 2'd1, 8'h7F, "R9 counting down");
        expect_item(0, 2'd3, 8'h02, "R9 cmp flag");
        bus_write(2'd3, 8'h02);
        bus_write(2'd1, 8'h01);
        run_ticks(2);
        expect_item(0, 2'd3, 8'h01, "R9 ovf at bottom");
        expect_item(0, 2'd1, 8'h01, "R9 turn at bottom");
        bus_write(2'd1, 8'h7F);
        run_ticks(2);
        expect_item(1, 2'd0, 8'h00, "R9 clear on up match");
        expect_item(0, 2'd1, 8'h81, "R9 counting up");

        // R10 interrupts
        bus_write(2'd3, 8'h30);
        expect_item(2, 2'd0, 8'h01, "R10 irq_ovf on");
        expect_item(3, 2'd0, 8'h01, "R10 irq_cmp on");
        expect_item(0, 2'd3, 8'h33, "R10 status");
        bus_write(2'd3, 8'h31);
        expect_item(2, 2'd0, 8'h00, "R10 irq_ovf cleared");
        expect_item(3, 2'd0, 8'h01, "R10 irq_cmp kept");
        expect_item(0, 2'd3, 8'h32, "R10 status after clear");

        // R11 clock select stop
        bus_write(2'd0, 8'h60);
        run_ticks(5);
        expect_item(0, 2'd1, 8'h81, "R11 stopped");

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule